// File: doc/BRIEF.md
# ADC Result Buffer Sequencer

This block sits between an analog-to-digital converter and the rest of the chip. Each time the converter reports a finished conversion (a one-cycle strobe together with a 12-bit result and the number of the converted channel), the sequencer stores the result in a 32-entry result memory and decides whether an interrupt is due. The memory is either addressed by the converted channel number, or filled as a FIFO. In FIFO mode it can also be split into a lower and an upper half that are filled in turn, so software reads one half while the converter fills the other.

The block also tells the converter which inputs to use for the next sample. There are two select sets, A and B. It can alternate between them on every sample, and the positive input of set A can step through a mask of scanned inputs. An interrupt is raised once every N+1 conversions, with N taken from a 5-bit field. Reference and offset-calibration settings are only stored here and read back.

Configuration goes through a 16-bit register write port with a registered read-back port. Results are read through a separate indexed read port.

Top module: `adc_result_sequencer`

## Requirements
- R1: After reset every configuration register reads 0, `irq` and `fill_upper` are 0, and set A is selected.
- R2: With rate field N (sequence register bits 4:0), `irq` pulses high for one cycle in the cycle after the strobe of the (N+1)-th accepted conversion of each period. N=0 interrupts on every conversion and N=31 on every 32nd.
- R3: With the channel-index bit (sequence register bit 6) set, each result is written to the entry whose index equals `conv_chan`.
- R4: In FIFO mode with the split bit (sequence register bit 5) clear, results fill entries 0, 1, 2, ... and every interrupt period starts again at entry 0.
- R5: In FIFO split mode, periods alternate between the lower half (base 0) and the upper half (base 16), starting with the lower half. Inside a half, the write pointer wraps from the half's last entry back to its base.
- R6: `fill_upper` (also status register bit 0, address 5) is 1 while the upper half is being filled, and 0 while the lower half is being filled or whenever split FIFO mode is not selected.
- R7: With the alternate bit (sequence register bit 7) set, the selects toggle between set A (address 2) and set B (address 3) after each conversion. With it clear, set A stays selected. Each select register holds the positive input in bits 4:0 and the negative input in bit 5.
- R8: With the scan bit (sequence register bit 8) set, the positive input of set A is the lowest set bit of the scan mask (address 4) at or after a scan position. After each set-A conversion the position moves past the used input, cyclically.
- R9: While the enable bit (control register bit 0, address 0) is clear, strobes are ignored. Clearing enable, or any write to the sequence register (address 1), returns the sample count, write pointer, half flag, A/B state and scan position to their start values. A strobe in the cycle of such a write is dropped.
- R10: Writes keep only the implemented bits: control 0x003D, sequence 0x01FF, select sets 0x003F, scan mask 0xFFFF. Unimplemented bits and unmapped addresses read 0.
- R11: `rd_data` shows the entry at `rd_addr` one cycle later. A read of an entry in the cycle it is written returns the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration write address |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_raddr | input | 3 | Configuration read address |
| cfg_rdata | output | 16 | Configuration read data, one cycle latency |
| conv_done | input | 1 | Conversion finished strobe |
| conv_chan | input | 5 | Channel number of the finished conversion |
| conv_data | input | 12 | Conversion result |
| rd_addr | input | 5 | Result memory read index |
| rd_data | output | 12 | Result memory read data, one cycle latency |
| irq | output | 1 | Interrupt pulse |
| fill_upper | output | 1 | Upper half is being filled |
| sel_set_b | output | 1 | Set B is selected for the next sample |
| sel_pos | output | 5 | Positive input for the next sample |
| sel_neg | output | 1 | Negative input for the next sample |

## Verification
Two pairs of functions can land in the same cycle. In the first, a sequence-register write and a conversion strobe are driven on the same edge. The restart must win: no interrupt follows, the next accepted conversion lands at entry 0, and the interrupt after that arrives exactly one full period later. In the second, a strobe and a result read address the same entry in one cycle. The read must return the old word, and a repeated read then returns the new one.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int REG_W  = 16;
  localparam int RADDR_W = 3;
  localparam int RATE_W = 5;
  localparam int POS_W  = 5;

  localparam logic [RADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [RADDR_W-1:0] A_SEQ  = 3'd1;
  localparam logic [RADDR_W-1:0] A_SELA = 3'd2;
  localparam logic [RADDR_W-1:0] A_SELB = 3'd3;
  localparam logic [RADDR_W-1:0] A_SCAN = 3'd4;
  localparam logic [RADDR_W-1:0] A_STAT = 3'd5;

  localparam logic [REG_W-1:0] M_CTRL = 16'h003D;
  localparam logic [REG_W-1:0] M_SEQ  = 16'h01FF;
  localparam logic [REG_W-1:0] M_SEL  = 16'h003F;

  typedef struct packed {
    logic              scan;
    logic              alt;
    logic              indexed;
    logic              split;
    logic [RATE_W-1:0] rate;
  } seq_cfg_t;

  typedef struct packed {
    logic             neg;
    logic [POS_W-1:0] pos;
  } sel_t;
endpackage

// File: rtl/adcseq_cfg.sv
module adcseq_cfg
  import adcseq_pkg::*;
#(
  parameter int SCANW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [RADDR_W-1:0] waddr,
  input  logic [REG_W-1:0]   wdata,
  input  logic [RADDR_W-1:0] raddr,
  output logic [REG_W-1:0]   rdata,
  input  logic               fill_upper,
  output logic               en,
  output seq_cfg_t           seq,
  output sel_t               sela,
  output sel_t               selb,
  output logic [SCANW-1:0]   scan_mask,
  output logic               seq_wr
);
  localparam logic [REG_W-1:0] M_SCAN = REG_W'((32'd1 << SCANW) - 1);

  logic [REG_W-1:0] ctrl_q, seq_q, sela_q, selb_q, scan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      seq_q  <= '0;
      sela_q <= '0;
      selb_q <= '0;
      scan_q <= '0;
    end else if (we) begin
      case (waddr)
        A_CTRL: ctrl_q <= wdata & M_CTRL;
        A_SEQ:  seq_q  <= wdata & M_SEQ;
        A_SELA: sela_q <= wdata & M_SEL;
        A_SELB: selb_q <= wdata & M_SEL;
        A_SCAN: scan_q <= wdata & M_SCAN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (raddr)
        A_CTRL:  rdata <= ctrl_q;
        A_SEQ:   rdata <= seq_q;
        A_SELA:  rdata <= sela_q;
        A_SELB:  rdata <= selb_q;
        A_SCAN:  rdata <= scan_q;
        A_STAT:  rdata <= {{(REG_W-1){1'b0}}, fill_upper};
        default: rdata <= '0;
      endcase
    end
  end

  assign en        = ctrl_q[0];
  assign seq       = seq_cfg_t'(seq_q[$bits(seq_cfg_t)-1:0]);
  assign sela      = sel_t'(sela_q[$bits(sel_t)-1:0]);
  assign selb      = sel_t'(selb_q[$bits(sel_t)-1:0]);
  assign scan_mask = scan_q[SCANW-1:0];
  assign seq_wr    = we && (waddr == A_SEQ);

  // R10: stored registers never hold an unimplemented bit
  assert_masked_R10: assert property (@(posedge clk) disable iff (rst)
    ((ctrl_q & ~M_CTRL) == '0) && ((seq_q & ~M_SEQ) == '0));
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          step,
  input  logic [AW-1:0] chan,
  input  seq_cfg_t      seq,
  output logic [AW-1:0] waddr,
  output logic          irq,
  output logic          half
);
  localparam int LW = AW - 1;
  localparam logic [AW-1:0] HALF_BASE = AW'(DEPTH / 2);

  logic [RATE_W-1:0] cnt;
  logic [AW-1:0]     wptr;
  logic              period_end;
  logic              half_n;
  logic [AW-1:0]     wptr_inc;

  assign period_end = (cnt == seq.rate);
  assign half_n     = seq.split ? ~half : 1'b0;
  assign wptr_inc   = seq.split ? {wptr[AW-1], LW'(wptr[LW-1:0] + 1'b1)}
                                : AW'(wptr + 1'b1);
  assign waddr      = seq.indexed ? chan : wptr;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      wptr <= '0;
      half <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= step && period_end;
      if (step) begin
        if (period_end) begin
          cnt <= '0;
          if (!seq.indexed) begin
            half <= half_n;
            wptr <= half_n ? HALF_BASE : '0;
          end
        end else begin
          cnt <= RATE_W'(cnt + 1'b1);
          if (!seq.indexed) wptr <= wptr_inc;
        end
      end
    end
  end

  assert_irq_after_done_R2: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(step));

  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= seq.rate);

  assert_ptr_in_half_R5: assert property (@(posedge clk) disable iff (rst)
    (seq.split && !seq.indexed) |-> (wptr[AW-1] == half));

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> (cnt == '0 && wptr == '0 && !half && !irq));
endmodule

// File: rtl/adcseq_insel.sv
module adcseq_insel
  import adcseq_pkg::*;
#(
  parameter int SCANW = 16,
  parameter int SIW   = $clog2(SCANW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step,
  input  logic             alt,
  input  logic             scan,
  input  sel_t             sela,
  input  sel_t             selb,
  input  logic [SCANW-1:0] mask,
  output logic             use_b,
  output logic [POS_W-1:0] pos,
  output logic             neg
);
  logic [SIW-1:0] sidx;
  logic [SIW-1:0] hit;

  function automatic logic [SIW-1:0] first_from(input logic [SCANW-1:0] m,
                                                input logic [SIW-1:0]   s);
    logic [SIW-1:0] r;
    r = '0;
    for (int k = SCANW - 1; k >= 0; k--) begin
      if (m[(int'(s) + k) % SCANW]) r = SIW'((int'(s) + k) % SCANW);
    end
    return r;
  endfunction

  assign hit = first_from(mask, sidx);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      sidx  <= '0;
      use_b <= 1'b0;
    end else if (step) begin
      use_b <= alt ? ~use_b : 1'b0;
      if (!use_b && scan) sidx <= SIW'((int'(hit) + 1) % SCANW);
    end
  end

  always_comb begin
    if (use_b) begin
      pos = selb.pos;
      neg = selb.neg;
    end else begin
      pos = scan ? POS_W'(hit) : sela.pos;
      neg = sela.neg;
    end
  end

  assert_alt_off_R7: assert property (@(posedge clk) disable iff (rst)
    !alt |-> !use_b);

  assert_scan_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!step && !restart) |=> $stable(sidx));
endmodule

// File: rtl/adcseq_ram.sv
module adcseq_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 12,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/adc_result_sequencer.sv
module adc_result_sequencer
  import adcseq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 12,
  parameter int SCANW = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [RADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  input  logic [RADDR_W-1:0] cfg_raddr,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic               conv_done,
  input  logic [AW-1:0]      conv_chan,
  input  logic [DW-1:0]      conv_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic               irq,
  output logic               fill_upper,
  output logic               sel_set_b,
  output logic [POS_W-1:0]   sel_pos,
  output logic               sel_neg
);
  logic             en, seq_wr, restart, step, half;
  seq_cfg_t         seq;
  sel_t             sela, selb;
  logic [SCANW-1:0] scan_mask;
  logic [AW-1:0]    waddr;

  assign restart    = !en || seq_wr;
  assign step       = conv_done && !restart;
  assign fill_upper = half && seq.split && !seq.indexed;

  adcseq_cfg #(.SCANW(SCANW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .raddr(cfg_raddr), .rdata(cfg_rdata), .fill_upper(fill_upper),
    .en(en), .seq(seq), .sela(sela), .selb(selb), .scan_mask(scan_mask),
    .seq_wr(seq_wr)
  );

  adcseq_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .restart(restart), .step(step), .chan(conv_chan),
    .seq(seq), .waddr(waddr), .irq(irq), .half(half)
  );

  adcseq_insel #(.SCANW(SCANW)) u_insel (
    .clk(clk), .rst(rst), .restart(restart), .step(step), .alt(seq.alt),
    .scan(seq.scan), .sela(sela), .selb(selb), .mask(scan_mask),
    .use_b(sel_set_b), .pos(sel_pos), .neg(sel_neg)
  );

  adcseq_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(step), .waddr(waddr), .wdata(conv_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // R9: no interrupt can follow a cycle with the converter disabled
  assert_no_irq_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!en) |-> !irq);
endmodule

// File: tb/tb_adc_result_sequencer.sv
module tb_adc_result_sequencer;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_addr, cfg_raddr;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        conv_done;
  logic [4:0]  conv_chan, rd_addr;
  logic [11:0] conv_data, rd_data;
  logic        irq, fill_upper, sel_set_b, sel_neg;
  logic [4:0]  sel_pos;

  int total = 0;
  int bad   = 0;
  bit fin   = 0;

  always #2 clk = ~clk;

  adc_result_sequencer dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .conv_done(conv_done), .conv_chan(conv_chan), .conv_data(conv_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .fill_upper(fill_upper),
    .sel_set_b(sel_set_b), .sel_pos(sel_pos), .sel_neg(sel_neg)
  );

  // {irq, fill_upper, addr[4:0], data[11:0]}: split FIFO, rate field 2
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 1'b0, 5'd0,  12'h100}, {1'b0, 1'b0, 5'd1,  12'h101},
    {1'b1, 1'b1, 5'd2,  12'h102}, {1'b0, 1'b1, 5'd16, 12'h103},
    {1'b0, 1'b1, 5'd17, 12'h104}, {1'b1, 1'b0, 5'd18, 12'h105},
    {1'b0, 1'b0, 5'd0,  12'h106}, {1'b0, 1'b0, 5'd1,  12'h107}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_cfg(input string req, input logic [2:0] a, input logic [15:0] exp);
    @(negedge clk);
    cfg_raddr = a;
    @(negedge clk);
    chk(req, cfg_rdata, exp);
  endtask

  task automatic conv(input logic [4:0] ch, input logic [11:0] d);
    @(negedge clk);
    conv_done = 1'b1; conv_chan = ch; conv_data = d;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic rd_buf(input string req, input logic [4:0] a, input logic [11:0] exp);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    chk(req, rd_data, exp);
  endtask

  task automatic sel_chk(input string req, input logic b, input logic [4:0] p, input logic n);
    chk(req, {sel_set_b, sel_pos, sel_neg}, {b, p, n});
  endtask

  initial begin
    #(4 * 150000);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int irqs;
    rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; cfg_raddr = 0;
    conv_done = 0; conv_chan = 0; conv_data = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 8; a++) rd_cfg("R1 reg", 3'(a), 16'h0);
    chk("R1 irq", irq, 0);
    chk("R1 fill", fill_upper, 0);
    sel_chk("R1 sel", 0, 0, 0);

    // R10: implemented bits only
    wr(3'd0, 16'hFFFF); rd_cfg("R10 ctrl", 3'd0, 16'h003D);
    wr(3'd1, 16'hFFFF); rd_cfg("R10 seq", 3'd1, 16'h01FF);
    wr(3'd2, 16'hFFFF); rd_cfg("R10 sela", 3'd2, 16'h003F);
    wr(3'd4, 16'hFFFF); rd_cfg("R10 scan", 3'd4, 16'hFFFF);
    wr(3'd6, 16'hFFFF); rd_cfg("R10 unmapped", 3'd6, 16'h0);
    wr(3'd2, 16'h0); wr(3'd4, 16'h0);
    wr(3'd0, 16'h0001);

    // R5/R2/R6: vector table, split FIFO, rate 2
    wr(3'd1, 16'h0022);
    for (int i = 0; i < 8; i++) begin
      conv(5'd0, VEC[i][11:0]);
      chk($sformatf("R2 irq vec%0d", i), irq, VEC[i][18]);
      chk($sformatf("R6 fill vec%0d", i), fill_upper, VEC[i][17]);
      rd_buf($sformatf("R5 addr vec%0d", i), VEC[i][16:12], VEC[i][11:0]);
    end

    // R4: non-split, rate 31
    wr(3'd1, 16'h001F);
    irqs = 0;
    for (int i = 0; i < 33; i++) begin
      conv(5'd0, 12'(12'h200 + i));
      if (irq) irqs++;
      if (i == 31) chk("R2 irq on 32nd", irq, 1);
    end
    chk("R2 single irq in 33", irqs, 1);
    rd_buf("R4 restart at 0", 5'd0, 12'h220);
    rd_buf("R4 entry 31", 5'd31, 12'h21F);
    rd_buf("R4 entry 5", 5'd5, 12'h205);

    // R5: split wrap inside a half, rate 20
    wr(3'd1, 16'h0034);
    irqs = 0;
    for (int i = 0; i < 21; i++) begin
      conv(5'd0, 12'(12'h300 + i));
      if (irq) irqs++;
    end
    chk("R2 irq count rate20", irqs, 1);
    rd_buf("R5 wrap to base", 5'd0, 12'h310);
    rd_buf("R5 last of half", 5'd15, 12'h30F);
    rd_buf("R5 after wrap", 5'd4, 12'h314);
    chk("R6 fill upper", fill_upper, 1);
    rd_cfg("R6 status reg", 3'd5, 16'h0001);
    conv(5'd0, 12'h3AA);
    rd_buf("R5 upper base", 5'd16, 12'h3AA);

    // R3: indexed with split set
    wr(3'd1, 16'h0060);
    conv(5'd9, 12'hABC);
    chk("R2 irq rate0", irq, 1);
    chk("R6 fill in indexed", fill_upper, 0);
    rd_buf("R3 chan9", 5'd9, 12'hABC);
    conv(5'd30, 12'h123);
    rd_buf("R3 chan30", 5'd30, 12'h123);

    // R11: read/write collision on entry 0
    wr(3'd1, 16'h001F);
    @(negedge clk);
    conv_done = 1'b1; conv_chan = 0; conv_data = 12'h4DD; rd_addr = 5'd0;
    @(negedge clk);
    conv_done = 1'b0;
    chk("R11 read-first", rd_data, 12'h310);
    @(negedge clk);
    chk("R11 new word", rd_data, 12'h4DD);

    // R9: sequence write coinciding with a strobe
    wr(3'd1, 16'h0001);
    conv(5'd0, 12'h501);
    chk("R2 no irq first", irq, 0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 16'h0001;
    conv_done = 1'b1; conv_data = 12'h555;
    @(negedge clk);
    cfg_we = 1'b0; conv_done = 1'b0;
    chk("R9 dropped no irq", irq, 0);
    conv(5'd0, 12'h502);
    chk("R9 fresh period", irq, 0);
    conv(5'd0, 12'h503);
    chk("R9 period end", irq, 1);
    rd_buf("R9 restart addr0", 5'd0, 12'h502);
    rd_buf("R9 addr1", 5'd1, 12'h503);

    // R9: disabled strobes ignored, enable clear restarts
    conv(5'd0, 12'h601);
    wr(3'd0, 16'h0000);
    conv(5'd0, 12'h6EE);
    chk("R9 off no irq", irq, 0);
    rd_buf("R9 off no write", 5'd1, 12'h503);
    wr(3'd0, 16'h0001);
    conv(5'd0, 12'h602);
    chk("R9 count restarted", irq, 0);
    conv(5'd0, 12'h603);
    chk("R9 irq after 2", irq, 1);
    rd_buf("R9 pointer restarted", 5'd0, 12'h602);

    // R7: alternate select sets
    wr(3'd2, 16'h0023);
    wr(3'd3, 16'h000A);
    wr(3'd1, 16'h0080);
    sel_chk("R7 start A", 0, 5'd3, 1);
    conv(5'd0, 12'h0);
    sel_chk("R7 then B", 1, 5'd10, 0);
    conv(5'd0, 12'h0);
    sel_chk("R7 back to A", 0, 5'd3, 1);
    wr(3'd1, 16'h0000);
    conv(5'd0, 12'h0);
    sel_chk("R7 alt off A", 0, 5'd3, 1);
    conv(5'd0, 12'h0);
    sel_chk("R7 alt off A again", 0, 5'd3, 1);

    // R8: scanning set A
    wr(3'd4, 16'h00A4);
    wr(3'd1, 16'h0100);
    sel_chk("R8 scan first", 0, 5'd2, 1);
    conv(5'd0, 12'h0);
    sel_chk("R8 scan second", 0, 5'd5, 1);
    conv(5'd0, 12'h0);
    sel_chk("R8 scan third", 0, 5'd7, 1);
    conv(5'd0, 12'h0);
    sel_chk("R8 scan wrap", 0, 5'd2, 1);
    wr(3'd1, 16'h0180);
    sel_chk("R8 scan alt A", 0, 5'd2, 1);
    conv(5'd0, 12'h0);
    sel_chk("R8 scan alt B", 1, 5'd10, 0);
    conv(5'd0, 12'h0);
    sel_chk("R8 scan alt A next", 0, 5'd5, 1);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule